// File: doc/BRIEF.md
# Thermostat Alarm with Consecutive-Fault Qualification

This block turns a stream of signed temperature samples into a single thermostat alarm pin. Each sample is taken in over a valid/ready handshake. It is compared against an upper trip limit and a lower hysteresis limit, and the comparison uses only as many most-significant bits as the resolution setting keeps. A programmable number of consecutive qualifying samples must be seen before the alarm asserts. This screens out isolated noisy readings.

Two alarm modes are provided. Comparator mode behaves like a thermostat: the alarm rises on sustained over-temperature and drops on the first sample below the hysteresis limit. Interrupt mode latches the alarm until software performs a register read, signalled here by a one-cycle pulse. After each clear, the watched limit alternates between the upper and the lower one. Shutdown forces the alarm inactive and suspends evaluation. The pin polarity is selectable.

Back-pressure rules: `smp_ready` is high in every cycle outside reset, so the block never stalls a producer. A sample is consumed on the rising clock edge where `smp_valid` and `smp_ready` are both high. Cycles with `smp_valid` low carry no sample and change nothing.

Top module: `thermo_alarm`

## Requirements
- R1: `smp_ready` is 0 during reset and 1 otherwise. A sample is taken only on an edge with `smp_valid`=1, and the alarm pin updates on that same edge. Cycles without a valid sample leave the alarm unchanged.
- R2: Comparisons are signed two's complement and strict. A sample qualifies high only if greater than the upper limit, and low only if less than the lower limit. Equal values do not qualify.
- R3: `cfg_res` = 0, 1, 2, 3 keeps the top 9, 10, 11 or 12 bits of the sample and of both limits. All lower bits are treated as zero in the comparison.
- R4: `cfg_fault` = 0, 1, 2, 3 requires 1, 2, 4 or 6 consecutive qualifying samples before the alarm asserts. A non-qualifying sample restarts the count from zero.
- R5: In comparator mode (`cfg_intr`=0), an inactive alarm watches the upper limit. An active alarm stays active until the first sample below the lower limit, which drops it on that sample's edge.
- R6: In interrupt mode (`cfg_intr`=1), an active alarm is not cleared by any sample. A `rd_pulse` cycle clears it on the following edge.
- R7: In interrupt mode, the watched limit starts at the upper one and flips each time the alarm asserts. After a clear, the next assertion needs the qualifying run on the other side.
- R8: `rd_pulse` has no effect in comparator mode.
- R9: While `cfg_shdn`=1, the alarm is forced inactive and samples are ignored. When shutdown is released, evaluation restarts from zero and watches the upper limit.
- R10: A change of `cfg_intr` resets the alarm to inactive and the count to zero, watching the upper limit.
- R11: `alarm_pin` equals the internal alarm state when `cfg_pol`=1 and its inverse when `cfg_pol`=0. After reset, the alarm is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high outside reset) |
| smp_data | input | TEMP_W | Signed temperature sample |
| lim_hi | input | TEMP_W | Upper trip limit, signed |
| lim_lo | input | TEMP_W | Lower hysteresis limit, signed |
| cfg_res | input | 2 | Resolution select |
| cfg_fault | input | 2 | Consecutive-fault count select |
| cfg_pol | input | 1 | 1 = active-high pin |
| cfg_intr | input | 1 | 1 = interrupt mode |
| cfg_shdn | input | 1 | Shutdown |
| rd_pulse | input | 1 | Register-read strobe, clears a latched alarm |
| alarm_pin | output | 1 | Alarm output at the selected polarity |

## Verification
The bench builds the block with its defaults: 16-bit samples and a 9-bit minimum resolution. This makes the coarse mask keep bits 15..7 and the finest keep bits 15..4. Limits are chosen just above each cut, so a single sample qualifies under one resolution and not under another. The 3-bit fault counter reaches its largest threshold of six, so the full queue and a run broken one sample short are both reachable. Negative samples against positive limits expose any unsigned comparison.

// File: rtl/thermo_alarm_pkg.sv
package thermo_alarm_pkg;
  localparam int FQ_W = 3;

  typedef enum logic {
    WATCH_HI = 1'b0,
    WATCH_LO = 1'b1
  } side_e;

  function automatic logic [FQ_W-1:0] fault_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    fault_limit = 3'd1;
      2'd1:    fault_limit = 3'd2;
      2'd2:    fault_limit = 3'd4;
      default: fault_limit = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/thermo_limit_cmp.sv
module thermo_limit_cmp #(
  parameter int TEMP_W   = 16,
  parameter int RES_BASE = 9
) (
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [1:0]        res,
  output logic              above,
  output logic              below
);
  localparam int LOW_ZEROS = TEMP_W - RES_BASE;

  logic [TEMP_W-1:0] keep_mask;
  logic [TEMP_W-1:0] s_m, h_m, l_m;

  always_comb begin
    keep_mask = {TEMP_W{1'b1}} << (LOW_ZEROS - int'(res));
    s_m   = sample & keep_mask;
    h_m   = lim_hi & keep_mask;
    l_m   = lim_lo & keep_mask;
    above = $signed(s_m) > $signed(h_m);
    below = $signed(s_m) < $signed(l_m);
  end
endmodule

// File: rtl/thermo_fault_cnt.sv
module thermo_fault_cnt
  import thermo_alarm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            valid,
  input  logic            qual,
  input  logic [FQ_W-1:0] thr,
  output logic            hit,
  output logic [FQ_W-1:0] cnt
);
  logic [FQ_W:0] nxt;

  always_comb begin
    nxt = {1'b0, cnt} + 1'b1;
    hit = valid && qual && !clr && (nxt >= {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (valid) begin
      if (!qual)      cnt <= '0;
      else if (hit)   cnt <= thr;
      else            cnt <= nxt[FQ_W-1:0];
    end
  end
endmodule

// File: rtl/thermo_alarm_fsm.sv
module thermo_alarm_fsm
  import thermo_alarm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            intr,
  input  logic            shdn,
  input  logic            acc,
  input  logic            above,
  input  logic            below,
  input  logic            hit,
  input  logic            rd,
  input  logic [FQ_W-1:0] cnt,
  input  logic [FQ_W-1:0] thr,
  output logic            act_q,
  output logic            qual,
  output logic            cnt_clr
);
  side_e side_q;
  logic  intr_q;
  logic  evt;

  always_comb begin
    evt     = shdn || (intr != intr_q);
    qual    = (intr && side_q == WATCH_LO) ? below : above;
    cnt_clr = evt || act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      side_q <= WATCH_HI;
      intr_q <= 1'b0;
    end else begin
      intr_q <= intr;
      if (evt) begin
        act_q  <= 1'b0;
        side_q <= WATCH_HI;
      end else if (intr) begin
        if (act_q) begin
          if (rd) act_q <= 1'b0;
        end else if (hit) begin
          act_q  <= 1'b1;
          side_q <= (side_q == WATCH_HI) ? WATCH_LO : WATCH_HI;
        end
      end else begin
        if (act_q) begin
          if (acc && below) act_q <= 1'b0;
        end else if (hit) act_q <= 1'b1;
      end
    end
  end

  // R5
  cmp_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!intr && act_q && !evt && !(acc && below)) |=> act_q);

  // R6
  intr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (intr && act_q && !evt && !rd) |=> act_q);

  // R4
  assert_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> ({1'b0, $past(cnt)} + 4'd1 >= {1'b0, $past(thr)}));

  // R1
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc && !evt && !rd) |=> $stable(act_q));
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
  import thermo_alarm_pkg::*;
#(
  parameter int TEMP_W   = 16,
  parameter int RES_BASE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [TEMP_W-1:0] smp_data,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [1:0]        cfg_res,
  input  logic [1:0]        cfg_fault,
  input  logic              cfg_pol,
  input  logic              cfg_intr,
  input  logic              cfg_shdn,
  input  logic              rd_pulse,
  output logic              alarm_pin
);
  logic            acc, above, below, qual, cnt_clr, hit, act;
  logic [FQ_W-1:0] thr, cnt;

  always_comb begin
    smp_ready = !rst;
    acc       = smp_valid && smp_ready && !cfg_shdn;
    thr       = fault_limit(cfg_fault);
    alarm_pin = cfg_pol ? act : !act;
  end

  thermo_limit_cmp #(.TEMP_W(TEMP_W), .RES_BASE(RES_BASE)) cmp_i (
    .sample(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo), .res(cfg_res),
    .above(above), .below(below)
  );

  thermo_fault_cnt cnt_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .valid(acc), .qual(qual),
    .thr(thr), .hit(hit), .cnt(cnt)
  );

  thermo_alarm_fsm fsm_i (
    .clk(clk), .rst(rst), .intr(cfg_intr), .shdn(cfg_shdn), .acc(acc),
    .above(above), .below(below), .hit(hit), .rd(rd_pulse), .cnt(cnt),
    .thr(thr), .act_q(act), .qual(qual), .cnt_clr(cnt_clr)
  );

  // R9
  shdn_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_shdn && $past(cfg_shdn)) |-> (alarm_pin == !cfg_pol));
endmodule

// File: tb/thermo_alarm_tb_top.sv
module thermo_alarm_tb_top;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [TW-1:0] smp_data = '0;
  logic [TW-1:0] lim_hi = 16'h5000;
  logic [TW-1:0] lim_lo = 16'h4B00;
  logic [1:0]    cfg_res = 2'd0;
  logic [1:0]    cfg_fault = 2'd0;
  logic          cfg_pol = 1'b0;
  logic          cfg_intr = 1'b0;
  logic          cfg_shdn = 1'b0;
  logic          rd_pulse = 1'b0;
  logic          alarm_pin;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  thermo_alarm dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo), .cfg_res(cfg_res),
    .cfg_fault(cfg_fault), .cfg_pol(cfg_pol), .cfg_intr(cfg_intr),
    .cfg_shdn(cfg_shdn), .rd_pulse(rd_pulse), .alarm_pin(alarm_pin)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic pin_of(input logic active);
    return cfg_pol ? active : !active;
  endfunction

  task automatic do_reset(input logic intr, input logic [1:0] fq, input logic pol);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; rd_pulse = 1'b0; cfg_shdn = 1'b0;
    cfg_intr = intr; cfg_fault = fq; cfg_pol = pol; cfg_res = 2'd0;
    lim_hi = 16'h5000; lim_lo = 16'h4B00;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [TW-1:0] v);
    smp_valid = 1'b1; smp_data = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready low in reset", smp_ready, 1'b0);
    do_reset(1'b0, 2'd0, 1'b0);
    chk("R1 ready high", smp_ready, 1'b1);
    chk("R11 reset inactive", alarm_pin, 1'b1);
  endtask

  task automatic t_comparator();
    do_reset(1'b0, 2'd0, 1'b0);
    send(16'h5000); chk("R2 equal upper no trip", alarm_pin, pin_of(1'b0));
    send(16'h8000); chk("R2 negative signed no trip", alarm_pin, pin_of(1'b0));
    smp_data = 16'h7000; repeat (2) @(negedge clk);
    chk("R1 valid low ignored", alarm_pin, pin_of(1'b0));
    send(16'h5080); chk("R5 trip above", alarm_pin, pin_of(1'b1));
    send(16'h4C00); chk("R5 hold between", alarm_pin, pin_of(1'b1));
    send(16'h4B00); chk("R2 equal lower hold", alarm_pin, pin_of(1'b1));
    pulse_rd();     chk("R8 read no effect", alarm_pin, pin_of(1'b1));
    send(16'h4A00); chk("R5 release below", alarm_pin, pin_of(1'b0));
  endtask

  task automatic t_fault_counts();
    do_reset(1'b0, 2'd1, 1'b0);
    send(16'h6000); chk("R4 fq2 one sample", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R4 fq2 second sample", alarm_pin, pin_of(1'b1));
    do_reset(1'b0, 2'd2, 1'b0);
    for (int i = 0; i < 3; i++) send(16'h6000);
    send(16'h5000); chk("R4 fq4 run broken", alarm_pin, pin_of(1'b0));
    for (int i = 0; i < 3; i++) send(16'h6000);
    chk("R4 fq4 three after break", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R4 fq4 fourth", alarm_pin, pin_of(1'b1));
    do_reset(1'b0, 2'd3, 1'b0);
    for (int i = 0; i < 5; i++) send(16'h6000);
    chk("R4 fq6 five", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R4 fq6 sixth", alarm_pin, pin_of(1'b1));
  endtask

  task automatic t_resolution();
    do_reset(1'b0, 2'd0, 1'b0);
    lim_hi = 16'h5040;
    cfg_res = 2'd1;
    send(16'h5060); chk("R3 10-bit masks difference", alarm_pin, pin_of(1'b0));
    cfg_res = 2'd3;
    send(16'h5060); chk("R3 12-bit sees difference", alarm_pin, pin_of(1'b1));
  endtask

  task automatic t_interrupt();
    do_reset(1'b1, 2'd0, 1'b0);
    send(16'h6000); chk("R6 intr trip", alarm_pin, pin_of(1'b1));
    send(16'h4000); chk("R6 sample does not clear", alarm_pin, pin_of(1'b1));
    pulse_rd();     chk("R6 read clears", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R7 upper ignored after clear", alarm_pin, pin_of(1'b0));
    send(16'h4000); chk("R7 lower trips", alarm_pin, pin_of(1'b1));
    pulse_rd();
    send(16'h4000); chk("R7 lower ignored next", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R7 back to upper", alarm_pin, pin_of(1'b1));
  endtask

  task automatic t_shutdown();
    do_reset(1'b1, 2'd0, 1'b0);
    send(16'h6000);
    cfg_shdn = 1'b1; @(negedge clk);
    chk("R9 shutdown clears", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R9 samples ignored", alarm_pin, pin_of(1'b0));
    cfg_shdn = 1'b0; @(negedge clk);
    send(16'h4000); chk("R9 lower not watched", alarm_pin, pin_of(1'b0));
    send(16'h6000); chk("R9 upper watched", alarm_pin, pin_of(1'b1));
  endtask

  task automatic t_mode_change();
    do_reset(1'b0, 2'd0, 1'b0);
    send(16'h6000);
    cfg_intr = 1'b1; @(negedge clk);
    chk("R10 mode change clears", alarm_pin, pin_of(1'b0));
    send(16'h4000); chk("R10 watching upper", alarm_pin, pin_of(1'b0));
  endtask

  task automatic t_polarity();
    do_reset(1'b0, 2'd0, 1'b1);
    chk("R11 active-high idle", alarm_pin, 1'b0);
    send(16'h6000); chk("R11 active-high on", alarm_pin, 1'b1);
    cfg_pol = 1'b0; #1;
    chk("R11 polarity flip", alarm_pin, 1'b0);
  endtask

  initial begin
    t_reset();
    t_comparator();
    t_fault_counts();
    t_resolution();
    t_interrupt();
    t_shutdown();
    t_mode_change();
    t_polarity();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule